// File: doc/BRIEF.md
# Addressed Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus. A front-end chip uses it to receive configuration from a bus master and to return that configuration on request. The master drives the clock line (SCL). The data line (SDA) is shared by all devices. The slave never drives SDA high. It only pulls the line low through an output enable, so any number of devices can share the line as a wired-AND. Both bus lines are brought into a faster system clock through two-flop synchronizers. Edges of the clock line and the START and STOP conditions are found from the synchronized samples.

Every transaction starts with a device byte. This byte holds the 7-bit device address, made of the fixed prefix 1010 followed by the three strap pins, and then a direction bit. The next byte selects a register. In a write, the bytes that follow are data stored at consecutive registers. In a read, there is no repeated START. Right after acknowledging the register byte, the slave sends the selected register and then the following registers, for as long as the master acknowledges each byte. Inside the chip, any register can be read at any time through a parallel index/data port.

The controller is a single state machine with these states:
- ST_IDLE: wait for START.
- ST_DEV_ADDR: shift in the device byte. At its end, go to ST_DEV_ACK on an address match, or to ST_WAIT_STOP on a mismatch.
- ST_DEV_ACK: acknowledge slot, then go to ST_REG_ADDR.
- ST_REG_ADDR: shift in the register byte, then go to ST_REG_ACK.
- ST_REG_ACK: acknowledge slot. Go to ST_WR_DATA for a write, or to ST_RD_DATA for a read.
- ST_WR_DATA: shift in a data byte, then go to ST_WR_ACK.
- ST_WR_ACK: acknowledge slot, then go back to ST_WR_DATA.
- ST_RD_DATA: shift out a data byte, then go to ST_RD_ACK.
- ST_RD_ACK: sample the master's answer. Go to ST_RD_DATA on ACK, or to ST_WAIT_STOP on not-ACK.
- ST_WAIT_STOP: stay silent.

From every state, START goes to ST_DEV_ADDR and STOP goes to ST_IDLE.

Top module: `cfg_link_slave`

## Requirements
- R1: The slave answers a device byte whose upper seven bits equal 1010 followed by addr_pins[2], addr_pins[1], addr_pins[0]. It answers by holding SDA low during the ninth clock. It also acknowledges the register byte and every written byte the same way.
- R2: When a device byte does not match, the slave drives SDA at no time before the next START or STOP, and no register changes.
- R3: In a write (direction bit 0), the first data byte is stored in the register selected by the register byte. The stored value then appears on host_data when host_idx selects that register.
- R4: Each further data byte in a write goes to the next register index, wrapping from 15 to 0.
- R5: In a read (direction bit 1), the slave sends the selected register's value MSB first, starting right after the acknowledge of the register byte.
- R6: During a read, a master ACK (SDA low on the ninth clock) makes the slave send the next register. A not-ACK makes the slave release SDA and stay silent until STOP or START.
- R7: Only the low four bits of the register byte select a register. The upper four bits have no effect.
- R8: The slave never pulls SDA low during bits that the master drives. It changes its output enable only while SCL is low.
- R9: A START at any point restarts reception of a device byte. A STOP at any point returns the slave to idle, and a data byte cut short by either one is not stored.
- R10: After reset, the output enable is low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line from the master |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| addr_pins | input | 3 | Strapped low bits of the device address |
| host_idx | input | 4 | Register index for the parallel read port |
| host_data | output | 8 | Contents of the register at host_idx |

## Verification
Writes are run as a single byte, as a three-byte burst that crosses the top of the register file, and with a register byte whose upper nibble is set. Together these separate correct storage from a failure to increment, a failure to wrap, or use of the full register byte. Reads are run as a single byte ended by not-ACK and as an acknowledged burst, which shows whether the slave advances and whether it goes silent after not-ACK. Two wrong addresses (one with a wrong pin bit, one with a wrong prefix) are tried alongside the matching one. A STOP in the middle of a data byte and a START right after an acknowledge show whether the slave can be aborted and then re-synchronized. The parallel port is compared with a behavioural register model on every idle clock, and the data line is watched on every clock of every master-driven bit.

// File: rtl/cls_pkg.sv
package cls_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } link_state_t;
endpackage

// File: rtl/cls_line_sync.sv
module cls_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] pipe;

    // Idle bus level is high, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe   <= '1;
            q_prev <= 1'b1;
        end else begin
            pipe   <= {pipe[STAGES-2:0], d_in};
            q_prev <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cls_regfile.sv
module cls_regfile #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] bus_raddr,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [IDX_W-1:0] host_raddr,
    output logic [WIDTH-1:0] host_rdata
);
    logic [WIDTH-1:0] regs [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (we && (waddr == IDX_W'(gi))) begin
                regs[gi] <= wdata;
            end
        end
    end

    assign bus_rdata  = regs[bus_raddr];
    assign host_rdata = regs[host_raddr];
endmodule

// File: rtl/cfg_link_slave.sv
module cfg_link_slave
    import cls_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        addr_pins,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [BYTE_W-1:0] host_data
);
    localparam logic [3:0] BITS_IN = 4'(BYTE_W);
    localparam logic [3:0] LAST_TX = 4'(BYTE_W - 1);

    // ---------------- line conditioning ----------------
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    cls_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_in(scl_i), .q(scl_s), .q_prev(scl_p)
    );
    cls_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_in(sda_i), .q(sda_s), .q_prev(sda_p)
    );

    assign scl_rise  =  scl_s && !scl_p;
    assign scl_fall  = !scl_s &&  scl_p;
    assign start_det =  scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  =  scl_s && scl_p && !sda_p && sda_s;

    // ---------------- datapath state ----------------
    link_state_t         cur, nxt;
    logic [3:0]          bit_cnt;
    logic [BYTE_W-1:0]   rx_sh, tx_sh;
    logic                rd_dir, master_ack;
    logic [IDX_W-1:0]    ptr;
    logic                rf_we;
    logic [IDX_W-1:0]    rf_waddr;
    logic [BYTE_W-1:0]   rf_wdata, bus_rdata;
    logic                byte_done, addr_hit;

    assign byte_done = scl_fall && (bit_cnt == BITS_IN);
    assign addr_hit  = (rx_sh[BYTE_W-1:1] == {DEV_PREFIX, addr_pins});

    cls_regfile #(.DEPTH(REG_COUNT), .WIDTH(BYTE_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .bus_raddr(ptr), .bus_rdata(bus_rdata),
        .host_raddr(host_idx), .host_rdata(host_data)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = cur;
        if (start_det) begin
            nxt = ST_DEV_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (cur)
                ST_IDLE, ST_WAIT_STOP: nxt = cur;
                ST_DEV_ADDR: if (byte_done) nxt = addr_hit ? ST_DEV_ACK : ST_WAIT_STOP;
                ST_DEV_ACK:  if (scl_fall)  nxt = ST_REG_ADDR;
                ST_REG_ADDR: if (byte_done) nxt = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall)  nxt = rd_dir ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)  nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && bit_cnt == LAST_TX) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  nxt = master_ack ? ST_RD_DATA : ST_WAIT_STOP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rd_dir     <= 1'b0;
            master_ack <= 1'b0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
            rf_we      <= 1'b0;
            rf_waddr   <= '0;
            rf_wdata   <= '0;
        end else begin
            rf_we <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (cur)
                    ST_DEV_ADDR, ST_REG_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (cur == ST_DEV_ADDR) begin
                                sda_oe <= addr_hit;
                                rd_dir <= rx_sh[0];
                            end else if (cur == ST_REG_ADDR) begin
                                sda_oe <= 1'b1;
                                ptr    <= rx_sh[IDX_W-1:0];
                            end else begin
                                sda_oe   <= 1'b1;
                                rf_we    <= 1'b1;
                                rf_waddr <= ptr;
                                rf_wdata <= rx_sh;
                                ptr      <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_REG_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_dir) begin
                                tx_sh  <= bus_rdata;
                                sda_oe <= !bus_rdata[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_TX) begin
                                sda_oe  <= 1'b0;
                                ptr     <= ptr + 1'b1;
                                bit_cnt <= '0;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe  <= !tx_sh[BYTE_W-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            master_ack <= !sda_s;
                        end else if (scl_fall && master_ack) begin
                            tx_sh  <= bus_rdata;
                            sda_oe <= !bus_rdata[BYTE_W-1];
                        end
                    end
                    ST_IDLE, ST_WAIT_STOP: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R8
    AST_SILENT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_WAIT_STOP || cur == ST_IDLE) |-> !sda_oe); // R2
    AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (cur == ST_DEV_ADDR)); // R9
    AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!scl_s && cur == ST_WR_ACK)); // R3
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (ptr == IDX_W'(rf_waddr + 1'b1))); // R4
    AST_TX_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_RD_DATA) |-> (sda_oe == !tx_sh[BYTE_W-1])); // R5
endmodule

// File: tb/test_cfg_link_slave.sv
module test_cfg_link_slave;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic [3:0] host_idx = '0;
    logic       sda_oe;
    logic [7:0] host_data;
    logic       sda_line;

    int   checks = 0;
    int   errors = 0;
    logic [7:0] model [16];
    bit   quiet = 1'b0;
    bit   cmp_en = 1'b0;

    localparam logic [6:0] MY_DEV  = 7'b1010101;
    localparam logic [6:0] BAD_PIN = 7'b1010100;
    localparam logic [6:0] BAD_PFX = 7'b0110101;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_link_slave i_cfg_link_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_pins(pins),
        .host_idx(host_idx), .host_data(host_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            if (quiet) check(!sda_oe, "R8 slave drove during master bit", sda_oe, 0);
            if (cmp_en) check(host_data == model[host_idx], "R3 parallel port vs model",
                              host_data, model[host_idx]);
            host_idx <= host_idx + 4'd1;
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, input bit mq, output logic s);
        if (!mq) quiet = 1'b0;
        ticks(4); m_sda = b; quiet = mq;
        ticks(4); scl = 1'b1;
        ticks(4); s = sda_line;
        ticks(4); scl = 1'b0;
    endtask

    task automatic bus_start();
        cmp_en = 1'b0;
        ticks(4); m_sda = 1'b1; quiet = 1'b1;
        ticks(4); scl = 1'b1;
        ticks(8); m_sda = 1'b0;
        ticks(8); scl = 1'b0;
    endtask

    task automatic bus_stop();
        ticks(4); m_sda = 1'b0; quiet = 1'b1;
        ticks(4); scl = 1'b1;
        ticks(8); m_sda = 1'b1;
        ticks(8); cmp_en = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit slave_slot, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], 1'b1, s);
        bus_bit(1'b1, !slave_slot, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, 1'b0, s);
            v[i] = s;
        end
        bus_bit(mack ? 1'b0 : 1'b1, 1'b1, s);
    endtask

    task automatic do_write(input logic [7:0] ra, input logic [7:0] d[$]);
        bit a;
        bus_start();
        send_byte({MY_DEV, 1'b0}, 1'b1, a);
        check(a, "R1 device byte ack (write)", a, 1);
        send_byte(ra, 1'b1, a);
        check(a, "R1 register byte ack", a, 1);
        foreach (d[i]) begin
            send_byte(d[i], 1'b1, a);
            check(a, "R1 data byte ack", a, 1);
            model[4'(ra[3:0] + i)] = d[i];
        end
        bus_stop();
        ticks(20);
    endtask

    task automatic do_read(input logic [7:0] ra, input int n, input string tag);
        bit a;
        logic s;
        logic [7:0] v;
        bus_start();
        send_byte({MY_DEV, 1'b1}, 1'b1, a);
        check(a, "R1 device byte ack (read)", a, 1);
        send_byte(ra, 1'b1, a);
        check(a, "R1 register byte ack (read)", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            check(v == model[4'(ra[3:0] + i)], tag, v, model[4'(ra[3:0] + i)]);
        end
        // R6: after not-ACK the line must stay released
        for (int i = 0; i < 4; i++) begin
            bus_bit(1'b1, 1'b1, s);
            check(s == 1'b1, "R6 silent after not-ACK", s, 1);
        end
        bus_stop();
        ticks(20);
    endtask

    task automatic wrong_dev(input logic [6:0] dev);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, 1'b0, a);
        check(!a, "R2 no ack for foreign address", a, 0);
        send_byte(8'h02, 1'b0, a);
        check(!a, "R2 no ack for register byte", a, 0);
        send_byte(8'hEE, 1'b0, a);
        check(!a, "R2 no ack for data byte", a, 0);
        bus_stop();
        ticks(20);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        logic s;
        foreach (model[i]) model[i] = 8'h00;
        ticks(5);
        rst_n = 1'b1;
        ticks(2);
        check(!sda_oe, "R10 output enable low after reset", sda_oe, 0);
        quiet = 1'b1;
        cmp_en = 1'b1;
        ticks(40);                              // R10 sweep of all registers

        do_write(8'h05, '{8'hA7});              // R3
        do_read(8'h05, 1, "R5 single read");
        do_write(8'h0E, '{8'h11, 8'h22, 8'h33}); // R4 wrap 14,15,0
        do_read(8'h0E, 3, "R6 burst read with ACK");
        do_write(8'hF3, '{8'h5C});              // R7 upper nibble ignored
        do_read(8'h03, 1, "R7 read back through low nibble");
        wrong_dev(BAD_PIN);                     // R2
        wrong_dev(BAD_PFX);                     // R2

        // R9: STOP in the middle of a data byte stores nothing
        bus_start();
        send_byte({MY_DEV, 1'b0}, 1'b1, a);
        check(a, "R9 device ack before abort", a, 1);
        send_byte(8'h07, 1'b1, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, 1'b1, s);
        bus_stop();
        ticks(20);
        check(model[7] == 8'h00, "R9 model untouched", model[7], 0);

        // R9: START right after the device acknowledge restarts addressing
        bus_start();
        send_byte({MY_DEV, 1'b0}, 1'b1, a);
        check(a, "R9 device ack before restart", a, 1);
        bus_start();
        send_byte({MY_DEV, 1'b0}, 1'b1, a);
        check(a, "R9 device ack after restart", a, 1);
        send_byte(8'h08, 1'b1, a);
        send_byte(8'h99, 1'b1, a);
        check(a, "R9 data ack after restart", a, 1);
        model[8] = 8'h99;
        bus_stop();
        ticks(40);
        do_read(8'h08, 1, "R9 read after restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule